// File: doc/BRIEF.md
# Thread Block Admission Controller

This controller places the thread blocks of one grid onto a set of compute units. Each unit keeps four free pools: registers, shared memory, thread slots and resident block slots. A pending block goes to a unit only when every one of the four pools can cover the block's request. The requests are the same for every block of the grid and come from configuration inputs that stay constant while the grid runs. Blocks are handed out one at a time as space opens. No schedule for the whole grid is worked out in advance.

An admitted block takes the lowest free block slot of its unit. It is split into warps of 32 threads, and the warps go to the unit's warp schedulers in rotation. The controller reports the scheduler that takes the first warp. The execution side reports each retiring warp by unit and slot. Pool space comes back only when the last warp of a block retires, and the freed space can be reused in that same cycle. Once the whole grid has been admitted and has retired, the controller raises a done flag.

Top module: `blk_admit_ctrl`

## Requirements
- R1: During reset and after it, adm_valid_o and grid_done_o are low until a grid is started.
- R2: A block is admitted to a unit only if free registers, free shared memory, free thread slots and a free block slot all cover its request. With the default parameters a unit holds 1024 registers, 4096 shared memory units, 256 thread slots and 4 block slots.
- R3: Blocks are admitted in ascending index order starting at 0, at most one per cycle. If the head block fits no unit, admission waits and no later block overtakes it. When several units fit, the lowest-numbered unit wins.
- R4: A block's warp count is its thread count divided by 32, rounded up, and is reported on adm_warps_o.
- R5: Each unit keeps a scheduler pointer that is 0 after a start. An admission reports the pointer on adm_sched_o, and the pointer then advances by the warp count, modulo the number of schedulers (default 4).
- R6: A warp retirement that is not the last one of its block returns no resources, so a block that did not fit before still does not fit afterwards.
- R7: When the last warp of a block retires, all four resources are returned in that cycle. An admission decided in the same cycle already sees the returned space and the freed slot.
- R8: A retirement aimed at an empty block slot is ignored.
- R9: grid_done_o rises one cycle after the cycle in which the last block's last warp retires, once all blocks have been admitted. It stays high until the next start. A start clears all per-unit state, and a grid of zero blocks completes one cycle after its start.
- R10: An admitted block takes the lowest-numbered free block slot of its unit.
- R11: An admission is decided from the state and retirement inputs of a cycle and is shown on the adm_* outputs for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts a grid with the current configuration |
| cfg_blocks_i | input | GRID_W | Number of blocks in the grid |
| cfg_regs_i | input | RW | Registers needed per block |
| cfg_smem_i | input | MW | Shared memory needed per block |
| cfg_threads_i | input | TW | Threads per block, at least 1 |
| wret_valid_i | input | 1 | A warp retires this cycle |
| wret_unit_i | input | UW | Unit of the retiring warp |
| wret_slot_i | input | SLW | Block slot of the retiring warp |
| adm_valid_o | output | 1 | An admission is reported this cycle |
| adm_unit_o | output | UW | Unit that received the block |
| adm_slot_o | output | SLW | Block slot used on that unit |
| adm_block_o | output | GRID_W | Index of the admitted block |
| adm_sched_o | output | SCW | Scheduler that takes the block's first warp |
| adm_warps_o | output | TW | Warp count of the block |
| grid_done_o | output | 1 | All blocks have been admitted and retired |

## Verification
The bench builds cases where exactly one of the four pools sets the limit: registers, thread slots together with shared memory, and block slots. A design that checked only some of the pools would over-admit and report admissions where none are expected. It retires all but the last warp of a blocked unit's block, which catches a design that frees space per warp and lets the waiting block in too early. It then retires the last warp in a cycle where a block is waiting, which catches a design that applies the release after the admission decision and so loses a cycle or picks a higher slot. A retirement aimed at an empty slot and a block of 200 threads also shake out counter underflow (the done flag would never rise), truncated warp counts and a scheduler pointer that steps by one instead of by the warp count.

// File: rtl/adm_pkg.sv
package adm_pkg;
  localparam int unsigned WARP_LANES = 32;

  // warps needed for a block of thr threads, rounded up
  function automatic int unsigned warps_for(input int unsigned thr);
    return (thr + WARP_LANES - 1) / WARP_LANES;
  endfunction

  // scheduler pointer after handing out nw warps starting at ptr
  function automatic int unsigned sched_after(input int unsigned ptr,
                                              input int unsigned nw,
                                              input int unsigned nsched);
    return (ptr + nw) % nsched;
  endfunction
endpackage

// File: rtl/adm_pick.sv
module adm_pick #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    gnt_o = '0;
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/adm_unit.sv
module adm_unit
  import adm_pkg::*;
#(
  parameter int REGS_CAP = 1024,
  parameter int SMEM_CAP = 4096,
  parameter int THR_CAP  = 256,
  parameter int SLOTS    = 4,
  parameter int NSCHED   = 4,
  localparam int RW  = $clog2(REGS_CAP + 1),
  localparam int MW  = $clog2(SMEM_CAP + 1),
  localparam int TW  = $clog2(THR_CAP + 1),
  localparam int SLW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int SCW = (NSCHED > 1) ? $clog2(NSCHED) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_i,
  input  logic [RW-1:0]  need_regs_i,
  input  logic [MW-1:0]  need_smem_i,
  input  logic [TW-1:0]  need_thr_i,
  input  logic [TW-1:0]  warps_i,
  input  logic           admit_i,
  input  logic           ret_v_i,
  input  logic [SLW-1:0] ret_slot_i,
  output logic           fits_o,
  output logic [SLW-1:0] slot_o,
  output logic [SCW-1:0] sched_o,
  output logic           busy_o
);
  logic [RW-1:0]  free_regs;
  logic [MW-1:0]  free_smem;
  logic [TW-1:0]  free_thr;
  logic [SCW-1:0] sched_ptr;
  logic [TW-1:0]  left_q [SLOTS];

  // named internal events
  logic          rel_ev;     // last warp of a resident block retires
  logic          slot_free;  // some block slot is free after release
  logic [RW:0]   eff_regs;
  logic [MW:0]   eff_smem;
  logic [TW:0]   eff_thr;

  assign rel_ev   = ret_v_i && (left_q[ret_slot_i] == TW'(1));
  assign eff_regs = {1'b0, free_regs} + (rel_ev ? {1'b0, need_regs_i} : '0);
  assign eff_smem = {1'b0, free_smem} + (rel_ev ? {1'b0, need_smem_i} : '0);
  assign eff_thr  = {1'b0, free_thr}  + (rel_ev ? {1'b0, need_thr_i}  : '0);

  always_comb begin
    slot_free = 1'b0;
    slot_o    = '0;
    busy_o    = 1'b0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (left_q[s] == '0 || (rel_ev && ret_slot_i == SLW'(s))) begin
        slot_free = 1'b1;
        slot_o    = SLW'(s);
      end
      if (left_q[s] != '0) busy_o = 1'b1;
    end
  end

  assign fits_o  = slot_free
                && (eff_regs >= {1'b0, need_regs_i})
                && (eff_smem >= {1'b0, need_smem_i})
                && (eff_thr  >= {1'b0, need_thr_i});
  assign sched_o = sched_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n || init_i) begin
      free_regs <= RW'(REGS_CAP);
      free_smem <= MW'(SMEM_CAP);
      free_thr  <= TW'(THR_CAP);
      sched_ptr <= '0;
      for (int s = 0; s < SLOTS; s++) left_q[s] <= '0;
    end else begin
      free_regs <= admit_i ? RW'(eff_regs - {1'b0, need_regs_i}) : RW'(eff_regs);
      free_smem <= admit_i ? MW'(eff_smem - {1'b0, need_smem_i}) : MW'(eff_smem);
      free_thr  <= admit_i ? TW'(eff_thr  - {1'b0, need_thr_i})  : TW'(eff_thr);
      if (admit_i)
        sched_ptr <= SCW'(sched_after(32'(sched_ptr), 32'(warps_i), NSCHED));
      for (int s = 0; s < SLOTS; s++) begin
        if (admit_i && slot_o == SLW'(s))
          left_q[s] <= warps_i;
        else if (ret_v_i && ret_slot_i == SLW'(s) && left_q[s] != '0)
          left_q[s] <= left_q[s] - TW'(1);
      end
    end
  end

  assert_admit_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    admit_i |-> fits_o);
  assert_pool_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (free_regs <= RW'(REGS_CAP)) && (free_smem <= MW'(SMEM_CAP)) && (free_thr <= TW'(THR_CAP)));
  assert_warp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_v_i && !rel_ev && !admit_i && !init_i) |=>
      (free_regs == $past(free_regs)) && (free_thr == $past(free_thr)));
  assert_block_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_ev && !admit_i && !init_i) |=>
      (free_regs == $past(free_regs) + $past(need_regs_i)) &&
      (free_smem == $past(free_smem) + $past(need_smem_i)));
endmodule

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl
  import adm_pkg::*;
#(
  parameter int NUM_UNITS    = 2,
  parameter int NUM_SCHED    = 4,
  parameter int UNIT_REGS    = 1024,
  parameter int UNIT_SMEM    = 4096,
  parameter int UNIT_THREADS = 256,
  parameter int UNIT_BSLOTS  = 4,
  parameter int GRID_W       = 16,
  localparam int RW  = $clog2(UNIT_REGS + 1),
  localparam int MW  = $clog2(UNIT_SMEM + 1),
  localparam int TW  = $clog2(UNIT_THREADS + 1),
  localparam int UW  = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int SLW = (UNIT_BSLOTS > 1) ? $clog2(UNIT_BSLOTS) : 1,
  localparam int SCW = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [GRID_W-1:0] cfg_blocks_i,
  input  logic [RW-1:0]     cfg_regs_i,
  input  logic [MW-1:0]     cfg_smem_i,
  input  logic [TW-1:0]     cfg_threads_i,
  input  logic              wret_valid_i,
  input  logic [UW-1:0]     wret_unit_i,
  input  logic [SLW-1:0]    wret_slot_i,
  output logic              adm_valid_o,
  output logic [UW-1:0]     adm_unit_o,
  output logic [SLW-1:0]    adm_slot_o,
  output logic [GRID_W-1:0] adm_block_o,
  output logic [SCW-1:0]    adm_sched_o,
  output logic [TW-1:0]     adm_warps_o,
  output logic              grid_done_o
);
  logic              running;
  logic [GRID_W-1:0] issued;
  logic [TW-1:0]     blk_warps;
  logic              pending;
  logic              any_busy;
  logic              gnt_any;
  logic [UW-1:0]     gnt_idx;
  logic [NUM_UNITS-1:0] unit_fits, unit_busy, unit_gnt, unit_req;
  logic [SLW-1:0]    unit_slot  [NUM_UNITS];
  logic [SCW-1:0]    unit_sched [NUM_UNITS];

  assign blk_warps = TW'(warps_for(32'(cfg_threads_i)));
  assign pending   = running && !start_i && (issued < cfg_blocks_i);
  assign unit_req  = pending ? unit_fits : '0;
  assign any_busy  = |unit_busy;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    adm_unit #(
      .REGS_CAP(UNIT_REGS), .SMEM_CAP(UNIT_SMEM), .THR_CAP(UNIT_THREADS),
      .SLOTS(UNIT_BSLOTS), .NSCHED(NUM_SCHED)
    ) u_unit (
      .clk(clk), .rst_n(rst_n), .init_i(start_i),
      .need_regs_i(cfg_regs_i), .need_smem_i(cfg_smem_i),
      .need_thr_i(cfg_threads_i), .warps_i(blk_warps),
      .admit_i(unit_gnt[u]),
      .ret_v_i(wret_valid_i && (wret_unit_i == UW'(u))),
      .ret_slot_i(wret_slot_i),
      .fits_o(unit_fits[u]), .slot_o(unit_slot[u]),
      .sched_o(unit_sched[u]), .busy_o(unit_busy[u])
    );
  end

  adm_pick #(.N(NUM_UNITS)) u_pick (
    .req_i(unit_req), .gnt_o(unit_gnt), .any_o(gnt_any), .idx_o(gnt_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running     <= 1'b0;
      issued      <= '0;
      grid_done_o <= 1'b0;
      adm_valid_o <= 1'b0;
      adm_unit_o  <= '0;
      adm_slot_o  <= '0;
      adm_block_o <= '0;
      adm_sched_o <= '0;
      adm_warps_o <= '0;
    end else begin
      adm_valid_o <= gnt_any;
      if (gnt_any) begin
        adm_unit_o  <= gnt_idx;
        adm_slot_o  <= unit_slot[gnt_idx];
        adm_block_o <= issued;
        adm_sched_o <= unit_sched[gnt_idx];
        adm_warps_o <= blk_warps;
        issued      <= issued + GRID_W'(1);
      end
      if (start_i) begin
        running     <= 1'b1;
        issued      <= '0;
        grid_done_o <= 1'b0;
      end else if (running && issued == cfg_blocks_i && !any_busy) begin
        running     <= 1'b0;
        grid_done_o <= 1'b1;
      end
    end
  end

  assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_gnt) && ((unit_gnt & unit_fits) == unit_gnt));
  assert_in_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adm_valid_o |-> (issued == $past(issued) + GRID_W'(1)) && (adm_block_o == $past(issued)));
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grid_done_o |-> !adm_valid_o && !any_busy);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> !grid_done_o);
endmodule

// File: tb/blk_admit_ctrl_bench.sv
`timescale 1ns/1ps
module blk_admit_ctrl_bench;
  localparam int GW = 16, RW = 11, MW = 13, TW = 9;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [GW-1:0] cfg_blocks_i = '0;
  logic [RW-1:0] cfg_regs_i = '0;
  logic [MW-1:0] cfg_smem_i = '0;
  logic [TW-1:0] cfg_threads_i = '0;
  logic wret_valid_i = 1'b0;
  logic [0:0] wret_unit_i = '0;
  logic [1:0] wret_slot_i = '0;
  logic adm_valid_o, grid_done_o;
  logic [0:0] adm_unit_o;
  logic [1:0] adm_slot_o, adm_sched_o;
  logic [GW-1:0] adm_block_o;
  logic [TW-1:0] adm_warps_o;

  int checks = 0, errors = 0;

  blk_admit_ctrl u_blk_admit_ctrl (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic rv; logic [0:0] ru; logic [1:0] rs;
    logic ev; logic [0:0] eu; logic [1:0] es; logic [3:0] eb; logic [1:0] esc;
    logic ed;
  } vec_t;

  // grid of 5, 400 regs, 1000 smem, 64 threads: registers limit a unit to 2 blocks
  localparam vec_t VEC [17] = '{
    '{1'b0,1'b0,2'd0, 1'b1,1'b0,2'd0,4'd0,2'd0, 1'b0},
    '{1'b0,1'b0,2'd0, 1'b1,1'b0,2'd1,4'd1,2'd2, 1'b0},
    '{1'b0,1'b0,2'd0, 1'b1,1'b1,2'd0,4'd2,2'd0, 1'b0},
    '{1'b0,1'b0,2'd0, 1'b1,1'b1,2'd1,4'd3,2'd2, 1'b0},
    '{1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0,4'd0,2'd0, 1'b0},
    '{1'b1,1'b1,2'd0, 1'b0,1'b0,2'd0,4'd0,2'd0, 1'b0},
    '{1'b1,1'b1,2'd0, 1'b1,1'b1,2'd0,4'd4,2'd0, 1'b0},
    '{1'b1,1'b0,2'd0, 1'b0,1'b0,2'd0,4'd0,2'd0, 1'b0},
    '{1'b1,1'b0,2'd0, 1'b0,1'b0,2'd0,4'd0,2'd0, 1'b0},
    '{1'b1,1'b0,2'd3, 1'b0,1'b0,2'd0,4'd0,2'd0, 1'b0},
    '{1'b1,1'b0,2'd1, 1'b0,1'b0,2'd0,4'd0,2'd0, 1'b0},
    '{1'b1,1'b0,2'd1, 1'b0,1'b0,2'd0,4'd0,2'd0, 1'b0},
    '{1'b1,1'b1,2'd1, 1'b0,1'b0,2'd0,4'd0,2'd0, 1'b0},
    '{1'b1,1'b1,2'd1, 1'b0,1'b0,2'd0,4'd0,2'd0, 1'b0},
    '{1'b1,1'b1,2'd0, 1'b0,1'b0,2'd0,4'd0,2'd0, 1'b0},
    '{1'b1,1'b1,2'd0, 1'b0,1'b0,2'd0,4'd0,2'd0, 1'b0},
    '{1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0,4'd0,2'd0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // drive a retirement (or none), cross one clock edge, sample 5 ns after it
  task automatic step(input bit rv, input int ru, input int rs);
    wret_valid_i = rv;
    wret_unit_i  = 1'(ru);
    wret_slot_i  = 2'(rs);
    @(posedge clk); #5;
    wret_valid_i = 1'b0;
  endtask

  task automatic start_grid(input int nb, input int rg, input int sm, input int th);
    cfg_blocks_i = GW'(nb); cfg_regs_i = RW'(rg); cfg_smem_i = MW'(sm); cfg_threads_i = TW'(th);
    start_i = 1'b1;
    @(posedge clk); #5;
    start_i = 1'b0;
  endtask

  task automatic expect_adm(input string req, input int u, input int s, input int b,
                            input int sc, input int w);
    chk(adm_valid_o === 1'b1, {req, " valid"}, int'(adm_valid_o), 1);
    chk(adm_unit_o == 1'(u), {req, " unit"}, int'(adm_unit_o), u);
    chk(adm_slot_o == 2'(s), {req, " slot"}, int'(adm_slot_o), s);
    chk(adm_block_o == GW'(b), {req, " block"}, int'(adm_block_o), b);
    chk(adm_sched_o == 2'(sc), {req, " sched"}, int'(adm_sched_o), sc);
    chk(adm_warps_o == TW'(w), {req, " R4 warps"}, int'(adm_warps_o), w);
  endtask

  task automatic expect_none(input string req);
    chk(adm_valid_o === 1'b0, {req, " no admission"}, int'(adm_valid_o), 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk); #5;
    chk(adm_valid_o === 1'b0, "R1 valid in reset", int'(adm_valid_o), 0);
    chk(grid_done_o === 1'b0, "R1 done in reset", int'(grid_done_o), 0);
    rst_n = 1'b1;
    step(0, 0, 0);
    chk(adm_valid_o === 1'b0 && grid_done_o === 1'b0, "R1 idle after reset",
        int'({adm_valid_o, grid_done_o}), 0);

    // table: R2 register limit, R3 order/lowest unit, R5 rotation, R6, R7, R8, R9, R10, R11
    start_grid(5, 400, 1000, 64);
    for (int i = 0; i < 17; i++) begin
      step(VEC[i].rv, int'(VEC[i].ru), int'(VEC[i].rs));
      if (VEC[i].ev)
        expect_adm($sformatf("R3 R7 R10 row%0d", i), int'(VEC[i].eu), int'(VEC[i].es),
                   int'(VEC[i].eb), int'(VEC[i].esc), 2);
      else
        expect_none($sformatf("R2 R6 R8 row%0d", i));
      chk(grid_done_o === VEC[i].ed, $sformatf("R9 done row%0d", i),
          int'(grid_done_o), int'(VEC[i].ed));
    end
    step(0, 0, 0);
    chk(grid_done_o === 1'b1, "R9 done sticky", int'(grid_done_o), 1);

    // 200 threads -> 7 warps; threads and shared memory allow one block per unit
    start_grid(3, 100, 3000, 200);
    chk(grid_done_o === 1'b0, "R9 start clears done", int'(grid_done_o), 0);
    step(0, 0, 0); expect_adm("R4 R5 first", 0, 0, 0, 0, 7);
    step(0, 0, 0); expect_adm("R3 second unit", 1, 0, 1, 0, 7);
    step(0, 0, 0); expect_none("R2 thread and smem limit");
    for (int k = 0; k < 6; k++) begin
      step(1, 0, 0); expect_none("R6 partial retire");
    end
    step(1, 0, 0); expect_adm("R5 R7 rotate by 7", 0, 0, 2, 3, 7);
    for (int k = 0; k < 7; k++) step(1, 1, 0);
    for (int k = 0; k < 7; k++) step(1, 0, 0);
    chk(grid_done_o === 1'b0, "R9 not yet", int'(grid_done_o), 0);
    step(0, 0, 0);
    chk(grid_done_o === 1'b1, "R9 grid done", int'(grid_done_o), 1);

    // block slots are the limit: 4 per unit
    start_grid(10, 10, 10, 32);
    for (int b = 0; b < 8; b++) begin
      step(0, 0, 0);
      expect_adm("R2 R10 slot fill", b / 4, b % 4, b, b % 4, 1);
    end
    step(0, 0, 0); expect_none("R2 block slot limit");
    step(1, 1, 2); expect_adm("R7 R10 reuse slot", 1, 2, 8, 0, 1);
    step(0, 0, 0); expect_none("R3 head waits");

    // empty grid
    start_grid(0, 10, 10, 32);
    chk(grid_done_o === 1'b0, "R9 empty grid start", int'(grid_done_o), 0);
    step(0, 0, 0);
    chk(grid_done_o === 1'b1 && adm_valid_o === 1'b0, "R9 empty grid done",
        int'({grid_done_o, adm_valid_o}), 2);

    finish_run();
  end
endmodule